// File: doc/BRIEF.md
# Direct-Mapped Cache Refill Controller

This block sits between a requester and a direct-mapped external cache. Each cache line holds a 20-bit tag, four tag parity bits and one data word. The controller looks up the line selected by the request's word address. It compares the stored tag with the address tag and checks the stored parity. On a hit it returns the cached word one cycle later. On a miss it asks main memory for a whole aligned block of 1, 4, 8, 16 or 32 words and writes every returned word into the cache. It releases the requester as soon as the word that missed arrives, and the rest of the block continues to fill in the background.

A two-bit compare mode is sampled on the first clock edge after reset is released. The mode can drop the four most significant tag bits, the four least significant tag bits, or both from the comparison. A smaller tag store can then be used when the memory is smaller or the cache is larger. Tag parity is checked in every mode.

The cache arrays and main memory are outside the block. The arrays are reached through a read port that answers in the same cycle and a write port. Memory is reached through a one-cycle request followed by a stream of valid-qualified data words.

Top module: `cache_refill_ctrl`

## Requirements
- R1: The controller samples `tag_mode_i` on the first rising clock edge after `rst_ni` goes high, and `ready_o` stays low until that edge. The encodings are 0 = compare all 20 tag bits, 1 = ignore tag bits 19:16, 2 = ignore tag bits 3:0, 3 = ignore both groups. Later changes to `tag_mode_i` have no effect.
- R2: The tag is `addr_i[29:10]` and the line index is `addr_i[9:0]`. A request is accepted when `req_i` and `ready_o` are both high at a clock edge. If the unmasked tag bits are equal and there is no parity error, the request is a hit. In the next cycle `rsp_valid_o` and `rsp_hit_o` are high and `rsp_data_o` equals the `cache_rd_data_i` sampled at acceptance, with no memory request.
- R3: Stored parity bit k is even parity over tag bits 5k+4..5k. A mismatch in any group is checked whatever the mode. It makes the request a miss and raises `perr_o` for exactly the one cycle after acceptance.
- R4: On a miss, `mem_req_o` is high for exactly the one cycle after acceptance. In that cycle `mem_addr_o` holds the block-aligned word address and `mem_len_o` the block length. `blk_sel_i` codes are 0→1, 1→4, 2→8, 3→16, and 4 or above→32 words.
- R5: Each `mem_valid_i` beat of a refill drives `cache_we_o` in the same cycle. The write goes to consecutive ascending indices starting at the block base. It carries the request tag, its even parity and `mem_data_i`.
- R6: One cycle after the beat that carries the missed word, `rsp_valid_o` is high with `rsp_hit_o` low and that word on `rsp_data_o`. The remaining beats are still written.
- R7: `ready_o` is low from the acceptance of a miss until the cycle after the final beat. Requests while it is low produce no response and no memory request.
- R8: While in reset and before the first edge after release, `ready_o`, `rsp_valid_o`, `perr_o`, `mem_req_o` and `cache_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tag_mode_i | input | 2 | Tag compare mode, sampled after reset |
| req_i | input | 1 | Lookup request |
| addr_i | input | WA_W | Request word address |
| blk_sel_i | input | 3 | Refill block length code |
| ready_o | output | 1 | Controller can accept a request |
| rsp_valid_o | output | 1 | Response word valid |
| rsp_hit_o | output | 1 | Response came from the cache |
| rsp_data_o | output | DATA_W | Response word |
| perr_o | output | 1 | Tag parity error pulse |
| cache_rd_idx_o | output | IDX_W | Cache read index |
| cache_rd_tag_i | input | 20 | Stored tag of the indexed line |
| cache_rd_par_i | input | 4 | Stored tag parity of the indexed line |
| cache_rd_data_i | input | DATA_W | Stored data of the indexed line |
| cache_we_o | output | 1 | Cache write strobe |
| cache_wr_idx_o | output | IDX_W | Cache write index |
| cache_wr_tag_o | output | 20 | Tag to write |
| cache_wr_par_o | output | 4 | Tag parity to write |
| cache_wr_data_o | output | DATA_W | Data to write |
| mem_req_o | output | 1 | Block fetch request pulse |
| mem_addr_o | output | WA_W | Block base word address |
| mem_len_o | output | 6 | Block length in words |
| mem_valid_i | input | 1 | Memory data beat valid |
| mem_data_i | input | DATA_W | Memory data beat |

## Verification
The assertions check on every cycle that the fetch request is a single-cycle pulse with an aligned base and a power-of-two length, and that a parity error always comes with a fetch and never with a response. They also check that cache writes step through ascending indices from the block base, that fetches and writes only happen while the controller is busy, and that a miss response always follows a write beat. Only the bench scenarios can show that each of the four latched modes gives the correct hit or miss for tag differences in each ignored and compared group. The scenarios also show that the missed word is released early at every offset and block length, that requests made during a refill are dropped, and that the refilled lines hold the memory contents.

// File: rtl/cache_refill_pkg.sv
package cache_refill_pkg;
  localparam int unsigned TAG_W = 20;
  localparam int unsigned PAR_W = 4;
  localparam int unsigned GRP_W = TAG_W / PAR_W;
  localparam int unsigned LEN_W = 6;
  localparam int unsigned OFF_W = 5;

  typedef enum logic [1:0] {
    CMP_ALL     = 2'd0,
    CMP_NO_HI   = 2'd1,
    CMP_NO_LO   = 2'd2,
    CMP_NO_BOTH = 2'd3
  } cmp_mode_e;

  typedef enum logic [1:0] {
    ST_CFG,
    ST_IDLE,
    ST_REQ,
    ST_FILL
  } fill_state_e;

  function automatic logic [PAR_W-1:0] tag_parity(input logic [TAG_W-1:0] tag);
    logic [PAR_W-1:0] p;
    for (int g = 0; g < PAR_W; g++) p[g] = ^tag[g*GRP_W +: GRP_W];
    return p;
  endfunction

  function automatic logic [TAG_W-1:0] cmp_mask(input cmp_mode_e m);
    logic [TAG_W-1:0] k;
    k = '1;
    if (m[0]) k[TAG_W-1 -: 4] = '0;
    if (m[1]) k[3:0] = '0;
    return k;
  endfunction

  function automatic logic [LEN_W-1:0] blk_words(input logic [2:0] sel);
    case (sel)
      3'd0:    return LEN_W'(1);
      3'd1:    return LEN_W'(4);
      3'd2:    return LEN_W'(8);
      3'd3:    return LEN_W'(16);
      default: return LEN_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/cache_tag_cmp.sv
module cache_tag_cmp
  import cache_refill_pkg::*;
(
  input  cmp_mode_e        mode_i,
  input  logic [TAG_W-1:0] stored_tag_i,
  input  logic [PAR_W-1:0] stored_par_i,
  input  logic [TAG_W-1:0] req_tag_i,
  output logic             match_o,
  output logic             par_err_o
);
  logic [PAR_W-1:0] grp_bad;

  for (genvar g = 0; g < PAR_W; g++) begin : g_grp
    assign grp_bad[g] = ^{stored_tag_i[g*GRP_W +: GRP_W], stored_par_i[g]};
  end

  // parity covers all groups regardless of mode
  assign par_err_o = |grp_bad;
  assign match_o   = ~|((stored_tag_i ^ req_tag_i) & cmp_mask(mode_i));
endmodule

// File: rtl/cache_refill_fsm.sv
module cache_refill_fsm
  import cache_refill_pkg::*;
#(
  parameter int unsigned WA_W  = 30,
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WA_W-1:0]  addr_i,
  input  logic [2:0]       blk_sel_i,
  input  logic             mem_valid_i,
  output fill_state_e      state_o,
  output logic             mem_req_o,
  output logic [WA_W-1:0]  mem_addr_o,
  output logic [LEN_W-1:0] mem_len_o,
  output logic             fill_we_o,
  output logic [IDX_W-1:0] fill_idx_o,
  output logic [TAG_W-1:0] fill_tag_o,
  output logic             crit_beat_o
);
  fill_state_e      state_q, state_d;
  logic [WA_W-1:0]  base_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic [OFF_W-1:0] crit_q;

  logic [LEN_W-1:0] len_n;
  logic [OFF_W-1:0] off_mask;
  logic [WA_W-1:0]  fill_word;
  logic             beat, last_beat;

  assign len_n    = blk_words(blk_sel_i);
  assign off_mask = len_n[OFF_W-1:0] - OFF_W'(1);

  assign beat      = (state_q == ST_FILL) && mem_valid_i;
  assign last_beat = (cnt_q == len_q - LEN_W'(1));
  assign fill_word = base_q + WA_W'(cnt_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CFG:  state_d = ST_IDLE;
      ST_IDLE: if (start_i) state_d = ST_REQ;
      ST_REQ:  state_d = ST_FILL;
      ST_FILL: if (beat && last_beat) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CFG;
      base_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      crit_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        base_q <= addr_i & ~WA_W'(off_mask);
        len_q  <= len_n;
        crit_q <= addr_i[OFF_W-1:0] & off_mask;
        cnt_q  <= '0;
      end else if (beat) begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

  assign state_o     = state_q;
  assign mem_req_o   = (state_q == ST_REQ);
  assign mem_addr_o  = base_q;
  assign mem_len_o   = len_q;
  assign fill_we_o   = beat;
  assign fill_idx_o  = fill_word[IDX_W-1:0];
  assign fill_tag_o  = fill_word[WA_W-1 -: TAG_W];
  assign crit_beat_o = beat && (cnt_q == {1'b0, crit_q});
endmodule

// File: rtl/cache_refill_ctrl.sv
module cache_refill_ctrl
  import cache_refill_pkg::*;
#(
  parameter int unsigned WA_W   = 30,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        tag_mode_i,
  input  logic              req_i,
  input  logic [WA_W-1:0]   addr_i,
  input  logic [2:0]        blk_sel_i,
  output logic              ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              perr_o,
  output logic [IDX_W-1:0]  cache_rd_idx_o,
  input  logic [TAG_W-1:0]  cache_rd_tag_i,
  input  logic [PAR_W-1:0]  cache_rd_par_i,
  input  logic [DATA_W-1:0] cache_rd_data_i,
  output logic              cache_we_o,
  output logic [IDX_W-1:0]  cache_wr_idx_o,
  output logic [TAG_W-1:0]  cache_wr_tag_o,
  output logic [PAR_W-1:0]  cache_wr_par_o,
  output logic [DATA_W-1:0] cache_wr_data_o,
  output logic              mem_req_o,
  output logic [WA_W-1:0]   mem_addr_o,
  output logic [LEN_W-1:0]  mem_len_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i
);
  fill_state_e      state;
  cmp_mode_e        mode_q;
  logic             fire, match, par_err, hit, crit_beat;
  logic [TAG_W-1:0] fill_tag;

  logic              rsp_valid_q, rsp_hit_q, perr_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign ready_o        = (state == ST_IDLE);
  assign fire           = req_i && ready_o;
  assign cache_rd_idx_o = addr_i[IDX_W-1:0];
  assign hit            = match && !par_err;

  cache_tag_cmp u_cmp (
    .mode_i      (mode_q),
    .stored_tag_i(cache_rd_tag_i),
    .stored_par_i(cache_rd_par_i),
    .req_tag_i   (addr_i[WA_W-1 -: TAG_W]),
    .match_o     (match),
    .par_err_o   (par_err)
  );

  cache_refill_fsm #(.WA_W(WA_W), .IDX_W(IDX_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (fire && !hit),
    .addr_i     (addr_i),
    .blk_sel_i  (blk_sel_i),
    .mem_valid_i(mem_valid_i),
    .state_o    (state),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_len_o  (mem_len_o),
    .fill_we_o  (cache_we_o),
    .fill_idx_o (cache_wr_idx_o),
    .fill_tag_o (fill_tag),
    .crit_beat_o(crit_beat)
  );

  // mode is taken once, on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= CMP_ALL;
    else if (state == ST_CFG) mode_q <= cmp_mode_e'(tag_mode_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      perr_q      <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= (fire && hit) || crit_beat;
      rsp_hit_q   <= fire && hit;
      perr_q      <= fire && par_err;
      if (fire && hit)   rsp_data_q <= cache_rd_data_i;
      else if (crit_beat) rsp_data_q <= mem_data_i;
    end
  end

  assign rsp_valid_o     = rsp_valid_q;
  assign rsp_hit_o       = rsp_hit_q;
  assign rsp_data_o      = rsp_data_q;
  assign perr_o          = perr_q;
  assign cache_wr_tag_o  = fill_tag;
  assign cache_wr_par_o  = tag_parity(fill_tag);
  assign cache_wr_data_o = mem_data_i;
endmodule

// File: rtl/cache_refill_ctrl_chk.sv
module cache_refill_ctrl_chk #(
  parameter int unsigned WA_W  = 30,
  parameter int unsigned IDX_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_hit_o,
  input logic             perr_o,
  input logic             cache_we_o,
  input logic [IDX_W-1:0] cache_wr_idx_o,
  input logic             mem_req_o,
  input logic [WA_W-1:0]  mem_addr_o,
  input logic [5:0]       mem_len_o
);
  logic [IDX_W-1:0] exp_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_idx <= '0;
    else if (mem_req_o) exp_idx <= mem_addr_o[IDX_W-1:0];
    else if (cache_we_o) exp_idx <= exp_idx + IDX_W'(1);
  end

  p_req_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  p_req_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_len_o) == 1) &&
                  ((mem_addr_o[4:0] & (mem_len_o[4:0] - 5'd1)) == 5'd0));

  p_perr_miss_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |-> mem_req_o && !rsp_valid_o);

  p_hit_nomem_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> !mem_req_o && ready_o);

  p_wr_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_we_o |-> cache_wr_idx_o == exp_idx);

  p_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || cache_we_o) |-> !ready_o);

  p_early_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> $past(cache_we_o));
endmodule

bind cache_refill_ctrl cache_refill_ctrl_chk #(.WA_W(WA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ready_o       (ready_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_hit_o     (rsp_hit_o),
  .perr_o        (perr_o),
  .cache_we_o    (cache_we_o),
  .cache_wr_idx_o(cache_wr_idx_o),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_len_o     (mem_len_o)
);

// File: tb/cache_refill_ctrl_bench.sv
module cache_refill_ctrl_bench;
  localparam int unsigned WA_W  = 30;
  localparam int unsigned IDX_W = 10;
  localparam int unsigned LINES = 1 << IDX_W;
  localparam time T_CLK = 8ns;

  logic clk_i = 1'b0;
  always #(T_CLK/2) clk_i = ~clk_i;

  logic        rst_ni = 1'b0;
  logic [1:0]  tag_mode_i = 2'd0;
  logic        req_i = 1'b0;
  logic [29:0] addr_i = '0;
  logic [2:0]  blk_sel_i = '0;
  logic        ready_o, rsp_valid_o, rsp_hit_o, perr_o;
  logic [31:0] rsp_data_o;
  logic [9:0]  cache_rd_idx_o, cache_wr_idx_o;
  logic [19:0] cache_rd_tag_i, cache_wr_tag_o;
  logic [3:0]  cache_rd_par_i, cache_wr_par_o;
  logic [31:0] cache_rd_data_i, cache_wr_data_o;
  logic        cache_we_o, mem_req_o;
  logic [29:0] mem_addr_o;
  logic [5:0]  mem_len_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_data_i = '0;

  cache_refill_ctrl #(.WA_W(WA_W), .IDX_W(IDX_W), .DATA_W(32)) u_cache_refill_ctrl (.*);

  // cache array model, written only here
  logic [19:0] c_tag  [LINES];
  logic [3:0]  c_par  [LINES];
  logic [31:0] c_data [LINES];
  logic        pre_we = 1'b0;
  logic [9:0]  pre_idx = '0;
  logic [19:0] pre_tag = '0;
  logic [3:0]  pre_par = '0;
  logic [31:0] pre_data = '0;

  assign cache_rd_tag_i  = c_tag[cache_rd_idx_o];
  assign cache_rd_par_i  = c_par[cache_rd_idx_o];
  assign cache_rd_data_i = c_data[cache_rd_idx_o];

  always @(posedge clk_i) begin
    if (cache_we_o) begin
      c_tag[cache_wr_idx_o]  <= cache_wr_tag_o;
      c_par[cache_wr_idx_o]  <= cache_wr_par_o;
      c_data[cache_wr_idx_o] <= cache_wr_data_o;
    end else if (pre_we) begin
      c_tag[pre_idx]  <= pre_tag;
      c_par[pre_idx]  <= pre_par;
      c_data[pre_idx] <= pre_data;
    end
  end

  function automatic logic [31:0] mem_word(input logic [29:0] w);
    return {w[15:0] ^ 16'hC3A5, w[29:14]};
  endfunction

  function automatic logic [3:0] even_par(input logic [19:0] t);
    logic [3:0] p;
    for (int g = 0; g < 4; g++) p[g] = ^t[g*5 +: 5];
    return p;
  endfunction

  function automatic int words(input logic [2:0] sel);
    case (sel)
      3'd0: return 1;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 16;
      default: return 32;
    endcase
  endfunction

  // memory model: beats start the cycle after the request, random gaps
  initial begin
    forever begin
      @(negedge clk_i);
      if (mem_req_o) begin
        automatic logic [29:0] b = mem_addr_o;
        automatic int n = int'(mem_len_o);
        @(negedge clk_i);
        for (int k = 0; k < n; k++) begin
          mem_valid_i = 1'b0;
          repeat ($urandom_range(0, 3)) @(negedge clk_i);
          mem_valid_i = 1'b1;
          mem_data_i  = mem_word(b + 30'(k));
          @(negedge clk_i);
        end
        mem_valid_i = 1'b0;
      end
    end
  end

  // monitor, sampled 1ns after the falling edge
  int n_rsp = 0, n_mreq = 0, ord_err = 0;
  logic [9:0] mon_base = '0;
  int mon_k = 0;
  initial begin
    forever begin
      @(negedge clk_i);
      #1ns;
      if (rsp_valid_o) n_rsp++;
      if (mem_req_o) begin
        n_mreq++;
        mon_base = mem_addr_o[9:0];
        mon_k = 0;
      end
      if (cache_we_o) begin
        if (cache_wr_idx_o != mon_base + 10'(mon_k)) ord_err++;
        mon_k++;
      end
    end
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #2ns;
  endtask

  task automatic set_line(input logic [9:0] i, input logic [19:0] t,
                          input logic [31:0] d, input logic [3:0] flip);
    pre_we = 1'b1; pre_idx = i; pre_tag = t; pre_par = even_par(t) ^ flip; pre_data = d;
    step();
    pre_we = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_ni = 1'b0; tag_mode_i = m; req_i = 1'b0;
    repeat (3) step();
    rst_ni = 1'b1;
    #1ns;
    chk("R8 ready", 64'(ready_o), 0);
    chk("R8 rsp/perr", 64'({rsp_valid_o, perr_o}), 0);
    chk("R8 mem_req/we", 64'({mem_req_o, cache_we_o}), 0);
    step();
    chk("R1 ready after mode capture", 64'(ready_o), 1);
    tag_mode_i = ~m;
  endtask

  task automatic access(input logic [29:0] a, input logic [2:0] sel,
                        input bit exp_hit, input bit exp_perr);
    int len, off, t;
    logic [29:0] base;
    logic [31:0] d_exp;
    int rsp0, mq0;
    bit ok;
    len  = words(sel);
    off  = int'(a[4:0]) & (len - 1);
    base = a - 30'(off);
    t = 0;
    while (!ready_o && t < 1000) begin step(); t++; end
    d_exp = c_data[a[9:0]];
    rsp0 = n_rsp; mq0 = n_mreq;
    req_i = 1'b1; addr_i = a; blk_sel_i = sel;
    step();
    chk("R3 perr pulse", 64'(perr_o), 64'(exp_perr));
    if (exp_hit) begin
      req_i = 1'b0;
      chk("R2 hit response", 64'({rsp_valid_o, rsp_hit_o, mem_req_o}), 64'(3'b110));
      chk("R2 hit data", 64'(rsp_data_o), 64'(d_exp));
    end else begin
      chk("R2 miss no hit rsp", 64'(rsp_valid_o), 0);
      chk("R4 mem_req", 64'(mem_req_o), 1);
      chk("R4 mem_addr", 64'(mem_addr_o), 64'(base));
      chk("R4 mem_len", 64'(mem_len_o), 64'(len));
      addr_i = a ^ 30'h0004_0000;  // held while busy, must be dropped
      t = 0;
      while (!rsp_valid_o && t < 500) begin step(); t++; end
      chk("R6 early rsp seen", 64'(rsp_valid_o), 1);
      chk("R6 early rsp miss", 64'(rsp_hit_o), 0);
      chk("R6 early data", 64'(rsp_data_o), 64'(mem_word(a)));
      chk("R6 ready vs offset", 64'(ready_o), 64'(off == len - 1));
      t = 0;
      while (!ready_o && t < 500) begin step(); t++; end
      req_i = 1'b0;
      step();
      chk("R7 one response", 64'(n_rsp - rsp0), 1);
      chk("R7 one fetch", 64'(n_mreq - mq0), 1);
      ok = 1'b1;
      for (int k = 0; k < len; k++) begin
        automatic logic [29:0] w = base + 30'(k);
        if (c_tag[w[9:0]] !== w[29:10] || c_par[w[9:0]] !== even_par(w[29:10]) ||
            c_data[w[9:0]] !== mem_word(w)) ok = 1'b0;
      end
      chk("R5 refilled lines", 64'(ok), 1);
    end
    step();
  endtask

  initial begin
    automatic logic [19:0] tb_tag = 20'h6B3C5;
    automatic logic [9:0]  li = 10'h2A4;
    automatic logic [19:0] deltas [5] = '{20'h00000, 20'h90000, 20'h00006, 20'h90006, 20'h00400};
    do_reset(2'd0);
    for (int i = 0; i < LINES; i++) set_line(10'(i), 20'h0, 32'h0, 4'h0);
    for (int m = 0; m < 4; m++) begin
      automatic logic [19:0] mask = 20'hFFFFF;
      if (m[0]) mask[19:16] = 4'h0;
      if (m[1]) mask[3:0] = 4'h0;
      do_reset(2'(m));
      for (int c = 0; c < 5; c++) begin
        set_line(li, tb_tag, 32'hD00D_0000 + 32'(c), 4'h0);
        // R2: hit iff masked tags agree
        access({tb_tag ^ deltas[c], li}, 3'((m + c) % 5), (deltas[c] & mask) == 20'h0, 1'b0);
      end
      // R5 R2: refilled line now hits
      access({tb_tag ^ 20'h00400, li}, 3'd0, 1'b1, 1'b0);
      // R3: parity error in a compared group and in an ignorable group
      set_line(li, tb_tag, 32'h1234_5678, 4'b0001);
      access({tb_tag, li}, 3'd1, 1'b0, 1'b1);
      set_line(li, tb_tag, 32'h1234_5678, 4'b1000);
      access({tb_tag, li}, 3'd2, 1'b0, 1'b1);
    end
    // R4 R5 R6: every block length, first, middle and last offset
    do_reset(2'd0);
    for (int s = 0; s < 6; s++) begin
      automatic int len = words(3'(s));
      automatic int offs [3] = '{0, len / 2, len - 1};
      for (int o = 0; o < 3; o++) begin
        access({20'h12345 + 20'(s * 3 + o), 10'h100 + 10'(offs[o])}, 3'(s), 1'b0, 1'b0);
      end
    end
    chk("R5 write order", 64'(ord_err), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(T_CLK * 150000);
    if (!done) begin
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end
endmodule